// File: doc/BRIEF.md
# Polled SPI Master with Transmit and Receive Queues

This block is an SPI bus master driven through a small word-addressed register port. Software programs the clock polarity, phase, frame width, a burst length and a clock divisor while the block is disabled. It picks one peripheral through a one-hot select register, loads outgoing frames into a 32-entry transmit queue, and then sets the enable bit. The shift engine then clocks out the programmed number of frames back to back, most significant bit first. Each frame received on the data-in line goes into a 32-entry receive queue.

Software paces itself by polling three status flags: busy, transmit queue full and receive queue empty. If the transmit queue runs dry in the middle of a burst, the engine parks with the serial clock at its idle level and resumes when the next word arrives. No frame is lost. Chip select is a plain register output, so it stays low from one frame to the next for as long as software leaves it set.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, `sclk` is 0, every `cs_n` line is 1 and the status word (address 5) reads 3'b100: bit 0 busy, bit 1 transmit full, bit 2 receive empty.
- R2: Writes to the config word (address 0: bit 0 polarity, bit 1 phase, bit 2 sixteen-bit frames), the frame count (address 1) and the divisor (address 4) take effect only while the enable bit (address 2, bit 0) is 0. Otherwise they are dropped, and reads return the held value.
- R3: A write of a value with at most one set bit to address 3 drives `cs_n = ~value`. A write with two or more set bits is dropped.
- R4: Setting enable starts a burst of count+1 frames. Busy reads 1 until the final edge of the last frame and then reads 0.
- R5: The serial clock period is 2*max(1, divisor>>1) input clock cycles. Outside an active frame, `sclk` sits at the polarity bit.
- R6: With phase 0, data-in is sampled on leading clock edges and data-out changes on trailing ones. With phase 1, data-out changes on leading edges (the first excepted) and sampling happens on trailing ones.
- R7: Frames are 8 bits, or 16 when config bit 2 is set, and are shifted MSB first. An 8-bit frame uses the low byte of the pushed word.
- R8: The first clock edge of a frame comes at least one half period after the frame is taken from the transmit queue.
- R9: With the transmit queue empty mid-burst, busy stays 1, `sclk` holds idle and no edge is produced until a word is pushed.
- R10: Each queue holds 32 words. Status bit 1 reads 1 with 32 words queued, and a push to address 6 while full is dropped.
- R11: A read of address 7 with the receive queue empty returns 0 and removes nothing.
- R12: Each finished frame pushes one word into the receive queue, right-justified with zero upper bits, and reads of address 7 return the words in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive queue at address 7) |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NCS | Active-low chip selects |

## Verification
Two pairs of operations can land in the same clock edge:
- the shift engine pushing a finished frame into the receive queue while a bus read pops it;
- a bus write filling the transmit queue while the engine takes a word from it.

Both are provoked with the smallest divisor, where frames finish every few cycles and the polling loop keeps both queues busy. The sweep runs every mode, both widths and two divisors, in 40-frame bursts that wrap the 32-entry queues. The result is judged by checking every received word and every frame seen on the data-out line against arithmetic patterns, in order. A lost or duplicated entry shows up as a mismatch.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
    localparam int FRAME_W = 16;

    localparam logic [2:0] A_CFG    = 3'd0;
    localparam logic [2:0] A_COUNT  = 3'd1;
    localparam logic [2:0] A_ENABLE = 3'd2;
    localparam logic [2:0] A_SELECT = 3'd3;
    localparam logic [2:0] A_DIV    = 3'd4;
    localparam logic [2:0] A_STATUS = 3'd5;
    localparam logic [2:0] A_TXDATA = 3'd6;
    localparam logic [2:0] A_RXDATA = 3'd7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT,
        ST_DONE
    } eng_state_e;
endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop,
    input  logic [WIDTH-1:0]           din,
    output logic [WIDTH-1:0]           dout,
    output logic                       full,
    output logic                       empty,
    output logic [$clog2(DEPTH):0]     level
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

    typedef struct packed {
        logic [AW:0] wr;
        logic [AW:0] rd;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign level   = ptr_q.wr - ptr_q.rd;
    assign full    = (level == FULL_LVL);
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem_q[ptr_q.rd[AW-1:0]];

    always_comb begin
        ptr_d = ptr_q;
        if (do_push) ptr_d.wr = ptr_q.wr + 1'b1;
        if (do_pop)  ptr_d.rd = ptr_q.rd + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[ptr_q.wr[AW-1:0]] <= din;
    end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_fifo_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DIV_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               cpol,
    input  logic               cpha,
    input  logic               wide,
    input  logic [CNT_W-1:0]   frames_m1,
    input  logic [DIV_W-1:0]   half,
    input  logic               tx_empty,
    input  logic [FRAME_W-1:0] tx_word,
    input  logic               miso,
    output logic               tx_pop,
    output logic               rx_push,
    output logic [FRAME_W-1:0] rx_word,
    output logic               sclk,
    output logic               mosi,
    output logic               busy
);
    typedef struct packed {
        eng_state_e         st;
        logic [DIV_W-1:0]   hcnt;
        logic [4:0]         ecnt;
        logic [CNT_W-1:0]   left;
        logic [FRAME_W-1:0] tx_sh;
        logic [FRAME_W-1:0] rx_sh;
        logic               sclk;
    } eng_t;

    eng_t eng_d, eng_q;
    logic [4:0] last_edge;

    assign last_edge = wide ? 5'd31 : 5'd15;

    always_comb begin
        eng_d   = eng_q;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        case (eng_q.st)
            ST_IDLE: begin
                eng_d.sclk = cpol;
                if (enable) begin
                    eng_d.st   = ST_LOAD;
                    eng_d.left = frames_m1;
                end
            end
            ST_LOAD: begin
                eng_d.sclk = cpol;
                if (!tx_empty) begin
                    tx_pop      = 1'b1;
                    eng_d.tx_sh = wide ? tx_word : {tx_word[7:0], 8'h00};
                    eng_d.rx_sh = '0;
                    eng_d.hcnt  = '0;
                    eng_d.ecnt  = '0;
                    eng_d.st    = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (eng_q.hcnt == half - DIV_W'(1)) begin
                    eng_d.hcnt = '0;
                    eng_d.sclk = ~eng_q.sclk;
                    if (eng_q.ecnt[0] == cpha)
                        eng_d.rx_sh = {eng_q.rx_sh[FRAME_W-2:0], miso};
                    else if (eng_q.ecnt != '0)
                        eng_d.tx_sh = {eng_q.tx_sh[FRAME_W-2:0], 1'b0};
                    if (eng_q.ecnt == last_edge) begin
                        rx_push = 1'b1;
                        if (eng_q.left == '0) begin
                            eng_d.st = ST_DONE;
                        end else begin
                            eng_d.left = eng_q.left - 1'b1;
                            eng_d.st   = ST_LOAD;
                        end
                    end else begin
                        eng_d.ecnt = eng_q.ecnt + 1'b1;
                    end
                end else begin
                    eng_d.hcnt = eng_q.hcnt + 1'b1;
                end
            end
            default: eng_d.sclk = cpol;
        endcase
        if (!enable) begin
            eng_d.st   = ST_IDLE;
            eng_d.sclk = cpol;
        end
        rx_word = wide ? eng_d.rx_sh : {8'h00, eng_d.rx_sh[7:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign sclk = (eng_q.st == ST_SHIFT) ? eng_q.sclk : cpol;
    assign mosi = eng_q.tx_sh[FRAME_W-1];
    assign busy = (eng_q.st == ST_LOAD) || (eng_q.st == ST_SHIFT);
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
    import spi_fifo_pkg::*;
#(
    parameter int NCS   = 4,
    parameter int DEPTH = 32,
    parameter int CNT_W = 16,
    parameter int DIV_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [2:0]     bus_addr,
    input  logic [31:0]    bus_wdata,
    output logic [31:0]    bus_rdata,
    output logic           sclk,
    output logic           mosi,
    input  logic           miso,
    output logic [NCS-1:0] cs_n
);
    localparam int LVL_W = $clog2(DEPTH) + 1;

    typedef struct packed {
        logic             cpol;
        logic             cpha;
        logic             wide;
        logic [CNT_W-1:0] count;
        logic             en;
        logic [NCS-1:0]   sel;
        logic [DIV_W-1:0] div;
    } regs_t;

    regs_t reg_d, reg_q;

    logic               tx_push, tx_pop, tx_full, tx_empty;
    logic               rx_push, rx_pop, rx_full_unused, rx_empty;
    logic [FRAME_W-1:0] tx_dout, rx_dout, rx_word;
    logic [LVL_W-1:0]   tx_level, rx_level_unused;
    logic [DIV_W-1:0]   half_per;
    logic               eng_busy;
    logic               unused_bits;

    assign unused_bits = ^bus_wdata[31:16];

    always_comb begin
        reg_d = reg_q;
        if (bus_wr) begin
            case (bus_addr)
                A_CFG: if (!reg_q.en) begin
                    reg_d.cpol = bus_wdata[0];
                    reg_d.cpha = bus_wdata[1];
                    reg_d.wide = bus_wdata[2];
                end
                A_COUNT:  if (!reg_q.en) reg_d.count = bus_wdata[CNT_W-1:0];
                A_ENABLE: reg_d.en = bus_wdata[0];
                A_SELECT: if ($countones(bus_wdata[NCS-1:0]) <= 1) reg_d.sel = bus_wdata[NCS-1:0];
                A_DIV:    if (!reg_q.en) reg_d.div = bus_wdata[DIV_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    assign tx_push  = bus_wr && (bus_addr == A_TXDATA);
    assign rx_pop   = bus_rd && (bus_addr == A_RXDATA);
    assign half_per = (reg_q.div[DIV_W-1:1] == '0) ? DIV_W'(1) : {1'b0, reg_q.div[DIV_W-1:1]};
    assign cs_n     = ~reg_q.sel;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CFG:    bus_rdata[2:0]       = {reg_q.wide, reg_q.cpha, reg_q.cpol};
            A_COUNT:  bus_rdata[CNT_W-1:0] = reg_q.count;
            A_ENABLE: bus_rdata[0]         = reg_q.en;
            A_SELECT: bus_rdata[NCS-1:0]   = reg_q.sel;
            A_DIV:    bus_rdata[DIV_W-1:0] = reg_q.div;
            A_STATUS: bus_rdata[2:0]       = {rx_empty, tx_full, eng_busy};
            A_RXDATA: if (!rx_empty) bus_rdata[FRAME_W-1:0] = rx_dout;
            default: ;
        endcase
    end

    spi_fifo #(.WIDTH(FRAME_W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .pop(tx_pop),
        .din(bus_wdata[FRAME_W-1:0]), .dout(tx_dout), .full(tx_full),
        .empty(tx_empty), .level(tx_level)
    );

    spi_fifo #(.WIDTH(FRAME_W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rx_pop),
        .din(rx_word), .dout(rx_dout), .full(rx_full_unused),
        .empty(rx_empty), .level(rx_level_unused)
    );

    spi_shift_engine #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .enable(reg_q.en), .cpol(reg_q.cpol),
        .cpha(reg_q.cpha), .wide(reg_q.wide), .frames_m1(reg_q.count),
        .half(half_per), .tx_empty(tx_empty), .tx_word(tx_dout), .miso(miso),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
        .sclk(sclk), .mosi(mosi), .busy(eng_busy)
    );
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
    parameter int DEPTH = 32,
    parameter int NCS   = 4,
    parameter int CFG_W = 35
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     sclk,
    input logic [NCS-1:0]           cs_n,
    input logic                     busy,
    input logic                     en,
    input logic                     cpol,
    input logic [CFG_W-1:0]         cfg_word,
    input logic [$clog2(DEPTH):0]   tx_level
);
    // R3
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en)) |-> $stable(cfg_word));

    // R5
    sclk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sclk) |-> ($past(busy) || !$stable(cpol)));

    // R10
    tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= ($clog2(DEPTH)+1)'(DEPTH));

    // R4
    busy_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (en || $past(en)));
endmodule

bind spi_fifo_master spi_fifo_master_chk #(
    .DEPTH(DEPTH), .NCS(NCS), .CFG_W(3 + CNT_W + DIV_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .busy(eng_busy),
    .en(reg_q.en), .cpol(reg_q.cpol),
    .cfg_word({reg_q.cpol, reg_q.cpha, reg_q.wide, reg_q.count, reg_q.div}),
    .tx_level(tx_level)
);

// File: tb/spi_fifo_master_tb.sv
module spi_fifo_master_tb;
    import spi_fifo_pkg::*;

    localparam int NCS   = 4;
    localparam int DEPTH = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_wr = 1'b0;
    logic           bus_rd = 1'b0;
    logic [2:0]     bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic           sclk, mosi, miso;
    logic [NCS-1:0] cs_n;

    int checks = 0;
    int errors = 0;

    int cpol_tb = 0, cpha_tb = 0, bits_tb = 8, mode_tb = 0, div_tb = 2;
    bit armed = 1'b0;
    int scount = 0;
    int lead_cnt = 0;
    logic [15:0] m_sh = '0;
    time t0 = 0, t1 = 0;

    always #4 clk = ~clk;

    spi_fifo_master #(.NCS(NCS), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    function automatic logic [15:0] t_word(input int k, input int m, input int d, input int b);
        logic [15:0] v;
        v = 16'(k * 113 + m * 7 + d * 3 + 16'h0F0F);
        return (b == 8) ? {8'h00, v[7:0]} : v;
    endfunction

    function automatic logic [15:0] s_word(input int k, input int m, input int b);
        logic [15:0] v;
        v = 16'(k * 59 + m * 5 + 16'hA5C3);
        return (b == 8) ? {8'h00, v[7:0]} : v;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // slave model: drives data-in from the sample count, checks data-out frames
    always_comb begin : miso_blk
        int fi;
        int bi;
        logic [15:0] w;
        fi = scount / bits_tb;
        bi = scount % bits_tb;
        w = s_word(fi, mode_tb, bits_tb);
        miso = w[bits_tb - 1 - bi];
    end

    always @(sclk) begin : slave_blk
        bit lead;
        int fi;
        logic [15:0] e;
        logic [15:0] got;
        if (armed && cs_n != '1) begin
            lead = (sclk != cpol_tb[0]);
            if (lead) begin
                if (lead_cnt == 0) t0 = $time;
                else if (lead_cnt == 1) t1 = $time;
                lead_cnt++;
            end
            if (lead == (cpha_tb == 0)) begin
                m_sh = {m_sh[14:0], mosi};
                scount++;
                if (scount % bits_tb == 0) begin
                    fi  = scount / bits_tb - 1;
                    e   = t_word(fi, mode_tb, div_tb, bits_tb);
                    got = (bits_tb == 8) ? {8'h00, m_sh[7:0]} : m_sh;
                    chk(got == e, "R6 R7 data-out frame", int'(got), int'(e));
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic run_burst(input int m, input int w, input int dv, input int nfr);
        int pushed;
        int got_n;
        int half;
        logic [31:0] st;
        logic [31:0] d;
        logic [15:0] e;
        time t_en;
        half    = ((dv >> 1) == 0) ? 1 : (dv >> 1);
        cpol_tb = m >> 1;
        cpha_tb = m & 1;
        mode_tb = m;
        div_tb  = dv;
        bits_tb = (w != 0) ? 16 : 8;
        wr(A_CFG, 32'((m >> 1) | ((m & 1) << 1) | (w << 2)));
        wr(A_COUNT, 32'(nfr - 1));
        wr(A_DIV, 32'(dv));
        wr(A_SELECT, 32'(1 << (m % NCS)));
        pushed = 0;
        while (pushed < nfr && pushed < DEPTH) begin
            wr(A_TXDATA, {16'h0, t_word(pushed, m, dv, bits_tb)});
            pushed++;
        end
        scount = 0; lead_cnt = 0; got_n = 0; armed = 1'b1;
        wr(A_ENABLE, 32'd1);
        t_en = $time - 4;
        rd(A_STATUS, st);
        chk(st[0] == 1'b1, "R4 busy after enable", int'(st[0]), 1);
        while (got_n < nfr) begin
            rd(A_STATUS, st);
            if (!st[1] && pushed < nfr) begin
                wr(A_TXDATA, {16'h0, t_word(pushed, m, dv, bits_tb)});
                pushed++;
            end
            if (!st[2]) begin
                rd(A_RXDATA, d);
                e = s_word(got_n, m, bits_tb);
                chk(d == {16'h0, e}, "R12 received word", int'(d), int'(e));
                got_n++;
            end
        end
        repeat (2) @(negedge clk);
        rd(A_STATUS, st);
        chk(st[0] == 1'b0, "R4 busy cleared after burst", int'(st[0]), 0);
        chk(scount == nfr * bits_tb, "R4 sample edge count", scount, nfr * bits_tb);
        chk((t1 - t0) == time'(2 * half * 8), "R5 sclk period", int'(t1 - t0), 2 * half * 8);
        chk((t0 - t_en) >= time'(half * 8) && (t0 - t_en) <= time'((half + 2) * 8),
            "R8 setup before first edge", int'(t0 - t_en), (half + 1) * 8);
        armed = 1'b0;
        wr(A_ENABLE, 32'd0);
        wr(A_SELECT, 32'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        int got_n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1
        chk(sclk == 1'b0, "R1 sclk at reset", int'(sclk), 0);
        chk(cs_n == '1, "R1 cs_n at reset", int'(cs_n), 15);
        rd(A_STATUS, d);
        chk(d == 32'h4, "R1 status at reset", int'(d), 4);

        // R3
        wr(A_SELECT, 32'h4);
        #1 chk(cs_n == 4'b1011, "R3 select one line", int'(cs_n), 11);
        wr(A_SELECT, 32'h6);
        #1 chk(cs_n == 4'b1011, "R3 multi-bit select dropped", int'(cs_n), 11);
        wr(A_SELECT, 32'h0);
        #1 chk(cs_n == 4'b1111, "R3 release all", int'(cs_n), 15);

        // R5 R6 R7 R12 sweep over modes, widths and divisors
        for (int m = 0; m < 4; m++)
            for (int w = 0; w < 2; w++)
                for (int k = 0; k < 2; k++)
                    run_burst(m, w, (k == 0) ? 2 : 5, 40);

        // R9 R10 R2 R11: overfilled queue, stall, config lock
        cpol_tb = 0; cpha_tb = 0; mode_tb = 0; div_tb = 2; bits_tb = 8;
        wr(A_CFG, 32'd0);
        wr(A_COUNT, 32'd32);
        wr(A_DIV, 32'd2);
        wr(A_SELECT, 32'd1);
        for (int i = 0; i < DEPTH; i++) wr(A_TXDATA, {16'h0, t_word(i, 0, 2, 8)});
        rd(A_STATUS, d);
        chk(d[1] == 1'b1, "R10 transmit full at 32", int'(d[1]), 1);
        wr(A_TXDATA, 32'hDEAD);
        scount = 0; lead_cnt = 0; armed = 1'b1;
        wr(A_ENABLE, 32'd1);
        got_n = 0;
        while (got_n < 32) begin
            rd(A_STATUS, d);
            if (!d[2]) begin
                rd(A_RXDATA, d);
                chk(d == {16'h0, s_word(got_n, 0, 8)}, "R12 received word", int'(d),
                    int'(s_word(got_n, 0, 8)));
                got_n++;
            end
        end
        repeat (100) @(negedge clk);
        rd(A_STATUS, d);
        chk(d[0] == 1'b1, "R9 busy held while starved", int'(d[0]), 1);
        chk(sclk == 1'b0, "R9 sclk idle while starved", int'(sclk), 0);
        chk(scount == 32 * 8, "R9 R10 no extra edges, push to full dropped", scount, 256);
        wr(A_CFG, 32'd7);
        rd(A_CFG, d);
        chk(d == 32'd0, "R2 config locked while enabled", int'(d), 0);
        wr(A_COUNT, 32'd5);
        rd(A_COUNT, d);
        chk(d == 32'd32, "R2 count locked while enabled", int'(d), 32);
        wr(A_TXDATA, {16'h0, t_word(32, 0, 2, 8)});
        while (got_n < 33) begin
            rd(A_STATUS, d);
            if (!d[2]) begin
                rd(A_RXDATA, d);
                chk(d == {16'h0, s_word(got_n, 0, 8)}, "R12 received word", int'(d),
                    int'(s_word(got_n, 0, 8)));
                got_n++;
            end
        end
        repeat (2) @(negedge clk);
        rd(A_STATUS, d);
        chk(d[0] == 1'b0, "R4 busy cleared after resume", int'(d[0]), 0);
        armed = 1'b0;
        wr(A_ENABLE, 32'd0);
        wr(A_SELECT, 32'd0);
        rd(A_RXDATA, d);
        chk(d == 32'd0, "R11 empty read returns zero", int'(d), 0);
        rd(A_STATUS, d);
        chk(d[2] == 1'b1, "R11 receive still empty", int'(d[2]), 1);
        wr(A_CFG, 32'd3);
        rd(A_CFG, d);
        chk(d == 32'd3, "R2 config accepted while disabled", int'(d), 3);
        #1 chk(sclk == 1'b1, "R5 idle level follows polarity", int'(sclk), 1);
        wr(A_CFG, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule